// File: doc/BRIEF.md
# Mode-Controlled Phase-Accumulator Oscillator

This block is the numerically controlled oscillator at the end of a digital clock-recovery loop. A phase accumulator advances once per system clock. Its most significant bit is the recovered clock. A one-cycle enable marks each rising edge of that bit. The recovered clock times the time-slot switching fabric and the serial stream outputs downstream.

A two-bit mode code from the loop's state controller chooses the increment added on each update.

- **Tracking:** the increment is the centre value plus the live, signed frequency correction from the loop filter.
- **Free-run:** the correction is ignored and the accumulator steps at the centre value.
- **Holdover:** the block replays a correction recorded earlier. That value is taken from a two-slot history, which is sampled on a millisecond tick. The history is deliberately aged by one to two bank periods, so the value replayed predates whatever disturbance forced the loop out of tracking.

Top module: `dco_mode_src`

## Requirements
- R1: With mode code 2'b01 (tracking), each clock `phase_o` advances by CENTER_INC plus `offset_i`, taken as an OFS_W-bit two's-complement value and sign-extended, modulo 2^ACC_W.
- R2: With mode code 2'b00 (free-run) or the unused code 2'b11, each clock `phase_o` advances by exactly CENTER_INC, whatever `offset_i` holds.
- R3: With mode code 2'b10 (holdover) and a held correction available, each clock `phase_o` advances by CENTER_INC plus the sign-extended held correction.
- R4: While tracking, the block records `offset_i` on every BANK_MS-th `ms_tick_i`, counted from entry into tracking. The held correction is the second-newest record. At exit from tracking, its age is at least BANK_MS and below 2*BANK_MS ticks.
- R5: In holdover with fewer than two records since the last entry into tracking, `phase_o` advances by CENTER_INC.
- R6: Outside tracking, no record is taken and the held correction does not change. On each new entry into tracking, all earlier records are discarded.
- R7: A change of mode code governs the very next accumulator update. The increment at a clock edge follows the mode present in the cycle before that edge.
- R8: `clk_o` equals the MSB of `phase_o`. `clk_en_o` is high exactly in the cycles where `clk_o` is 1 and was 0 in the cycle before.
- R9: During and right after reset, `phase_o` is 0, `clk_o` and `clk_en_o` are 0, and the history is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | 00 free-run, 01 tracking, 10 holdover, 11 treated as free-run |
| offset_i | input | OFS_W | Signed frequency correction from the loop filter |
| ms_tick_i | input | 1 | One-cycle pulse each millisecond |
| phase_o | output | ACC_W | Phase accumulator value |
| clk_o | output | 1 | Recovered clock (accumulator MSB) |
| clk_en_o | output | 1 | One-cycle pulse on each rising edge of `clk_o` |

## Verification
The bench builds the block with ACC_W=12, OFS_W=8, CENTER_INC=300 and BANK_MS=4, and issues a tick every third clock. With these values the accumulator wraps roughly every fourteen cycles, so many edges of the recovered clock and their enables appear in a short run. A full history needs only 24 clocks of tracking, so the age window, holdover with partial history and the discard on re-entry are each reached several times. Corrections of about ±100 against a centre of 300 make an ignored or mis-aged correction show up as a different phase step on the very next cycle.

// File: rtl/dco_pkg.sv
package dco_pkg;

  typedef enum logic [1:0] {
    MODE_FREE = 2'b00,
    MODE_TRK  = 2'b01,
    MODE_HOLD = 2'b10,
    MODE_RSVD = 2'b11
  } dco_mode_e;

  // Source of the correction added to the centre step
  typedef enum logic [1:0] {
    SRC_CENTER = 2'b00,
    SRC_LIVE   = 2'b01,
    SRC_HELD   = 2'b10
  } dco_src_e;

  function automatic logic f_is_tracking(input logic [1:0] m);
    return m == MODE_TRK;
  endfunction

  function automatic logic f_is_hold(input logic [1:0] m);
    return m == MODE_HOLD;
  endfunction

  function automatic dco_src_e f_pick_src(input logic [1:0] m, input logic held_ok);
    dco_src_e s;
    s = SRC_CENTER;
    if (f_is_tracking(m))            s = SRC_LIVE;
    else if (f_is_hold(m) && held_ok) s = SRC_HELD;
    return s;
  endfunction

endpackage

// File: rtl/dco_hist_bank.sv
module dco_hist_bank #(
  parameter int OFS_W   = 16,
  parameter int BANK_MS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trk_i,
  input  logic             tick_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic [OFS_W-1:0] held_o,
  output logic             held_vld_o,
  output logic             snap_o,
  output logic             entry_o
);
  localparam int NBANK = 2;
  localparam int CNT_W = $clog2(BANK_MS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BANK_MS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             prev_trk_q;
  logic [OFS_W-1:0] bank_q [NBANK];
  logic [NBANK-1:0] vld_q;
  logic             bank_end;

  assign entry_o  = trk_i & ~prev_trk_q;
  assign bank_end = tick_i & (cnt_q == CNT_LAST);
  assign snap_o   = trk_i & bank_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      prev_trk_q <= 1'b0;
    end else begin
      prev_trk_q <= trk_i;
      if (!trk_i)       cnt_q <= '0;
      else if (bank_end) cnt_q <= '0;
      else if (tick_i)   cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // Slot 0 holds the newest record, slot NBANK-1 the oldest
  for (genvar g = 0; g < NBANK; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank_q[g] <= '0;
        vld_q[g]  <= 1'b0;
      end else if (entry_o) begin
        vld_q[g]  <= 1'b0;
      end else if (snap_o) begin
        if (g == 0) begin
          bank_q[g] <= ofs_i;
          vld_q[g]  <= 1'b1;
        end else begin
          bank_q[g] <= bank_q[g-1];
          vld_q[g]  <= vld_q[g-1];
        end
      end
    end
  end

  assign held_o     = bank_q[NBANK-1];
  assign held_vld_o = vld_q[NBANK-1];

endmodule

// File: rtl/dco_inc_sel.sv
module dco_inc_sel
  import dco_pkg::*;
#(
  parameter int          ACC_W      = 32,
  parameter int          OFS_W      = 16,
  parameter int unsigned CENTER_INC = 32'h4000_0000
) (
  input  logic [1:0]       mode_i,
  input  logic [OFS_W-1:0] live_i,
  input  logic [OFS_W-1:0] held_i,
  input  logic             held_vld_i,
  output logic [ACC_W-1:0] inc_o,
  output dco_src_e         src_o
);
  localparam int EXT_W = ACC_W - OFS_W;

  function automatic logic [ACC_W-1:0] f_widen(input logic [OFS_W-1:0] o);
    return {{EXT_W{o[OFS_W-1]}}, o};
  endfunction

  function automatic logic [ACC_W-1:0] f_step(input dco_src_e s,
                                               input logic [OFS_W-1:0] lv,
                                               input logic [OFS_W-1:0] hd);
    logic [ACC_W-1:0] corr;
    case (s)
      SRC_LIVE: corr = f_widen(lv);
      SRC_HELD: corr = f_widen(hd);
      default:  corr = '0;
    endcase
    return ACC_W'(CENTER_INC) + corr;
  endfunction

  always_comb begin
    src_o = f_pick_src(mode_i, held_vld_i);
    inc_o = f_step(src_o, live_i, held_i);
  end

endmodule

// File: rtl/dco_phase_acc.sv
module dco_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] inc_i,
  output logic [ACC_W-1:0] phase_o,
  output logic             msb_o,
  output logic             rise_o
);
  logic [ACC_W-1:0] acc_q;
  logic             msb_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q      <= '0;
      msb_prev_q <= 1'b0;
    end else begin
      acc_q      <= acc_q + inc_i;
      msb_prev_q <= acc_q[ACC_W-1];
    end
  end

  assign phase_o = acc_q;
  assign msb_o   = acc_q[ACC_W-1];
  assign rise_o  = acc_q[ACC_W-1] & ~msb_prev_q;

endmodule

// File: rtl/dco_mode_src.sv
module dco_mode_src
  import dco_pkg::*;
#(
  parameter int          ACC_W      = 32,
  parameter int          OFS_W      = 16,
  parameter int unsigned CENTER_INC = 32'h4000_0000,
  parameter int          BANK_MS    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic [OFS_W-1:0] offset_i,
  input  logic             ms_tick_i,
  output logic [ACC_W-1:0] phase_o,
  output logic             clk_o,
  output logic             clk_en_o
);
  // Named internal events, visible to the bound checker
  logic             trk_w;
  logic [OFS_W-1:0] held_w;
  logic             held_vld_w;
  logic             snap_w;
  logic             entry_w;
  logic [ACC_W-1:0] inc_w;
  dco_src_e         src_w;

  assign trk_w = f_is_tracking(mode_i);

  dco_hist_bank #(.OFS_W(OFS_W), .BANK_MS(BANK_MS)) u_hist (
    .clk(clk), .rst_n(rst_n), .trk_i(trk_w), .tick_i(ms_tick_i),
    .ofs_i(offset_i), .held_o(held_w), .held_vld_o(held_vld_w),
    .snap_o(snap_w), .entry_o(entry_w)
  );

  dco_inc_sel #(.ACC_W(ACC_W), .OFS_W(OFS_W), .CENTER_INC(CENTER_INC)) u_sel (
    .mode_i(mode_i), .live_i(offset_i), .held_i(held_w),
    .held_vld_i(held_vld_w), .inc_o(inc_w), .src_o(src_w)
  );

  dco_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .inc_i(inc_w),
    .phase_o(phase_o), .msb_o(clk_o), .rise_o(clk_en_o)
  );

endmodule

// File: rtl/dco_mode_src_chk.sv
module dco_mode_src_chk #(
  parameter int          ACC_W      = 32,
  parameter int          OFS_W      = 16,
  parameter int unsigned CENTER_INC = 32'h4000_0000
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_i,
  input logic [OFS_W-1:0] offset_i,
  input logic             ms_tick_i,
  input logic [ACC_W-1:0] phase_o,
  input logic             clk_o,
  input logic             clk_en_o,
  input logic [OFS_W-1:0] held_w,
  input logic             held_vld_w,
  input logic             snap_w,
  input logic             entry_w
);
  localparam logic [ACC_W-1:0] CTR = ACC_W'(CENTER_INC);

  function automatic logic [ACC_W-1:0] sx(input logic [OFS_W-1:0] v);
    return {{(ACC_W-OFS_W){v[OFS_W-1]}}, v};
  endfunction

  p_track_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b01) |=> (phase_o == $past(phase_o) + CTR + sx($past(offset_i))));

  p_free_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i[1] == mode_i[0]) |=> (phase_o == $past(phase_o) + CTR));

  p_hold_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b10 && held_vld_w) |=> (phase_o == $past(phase_o) + CTR + sx($past(held_w))));

  p_snap_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    snap_w |-> (mode_i == 2'b01 && ms_tick_i));

  p_hold_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b10 && !held_vld_w) |=> (phase_o == $past(phase_o) + CTR));

  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != 2'b01) |=> ($stable(held_w) && $stable(held_vld_w)));

  p_reentry_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    entry_w |=> !held_vld_w);

  p_en_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_o |-> clk_o);

  p_en_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_o) |-> clk_en_o);

  p_en_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_o |=> !clk_en_o);

endmodule

bind dco_mode_src dco_mode_src_chk #(
  .ACC_W(ACC_W), .OFS_W(OFS_W), .CENTER_INC(CENTER_INC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .offset_i(offset_i),
  .ms_tick_i(ms_tick_i), .phase_o(phase_o), .clk_o(clk_o),
  .clk_en_o(clk_en_o), .held_w(held_w), .held_vld_w(held_vld_w),
  .snap_w(snap_w), .entry_w(entry_w)
);

// File: tb/tb_dco_mode_src.sv
module tb_dco_mode_src;
  localparam int ACC_W  = 12;
  localparam int OFS_W  = 8;
  localparam int CENTER = 300;
  localparam int BANK   = 4;
  localparam int TPER   = 3;
  localparam int MASK   = (1 << ACC_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       mode_i = 2'b00;
  logic [OFS_W-1:0] offset_i = '0;
  logic             ms_tick_i = 1'b0;
  logic [ACC_W-1:0] phase_o;
  logic             clk_o;
  logic             clk_en_o;

  dco_mode_src #(.ACC_W(ACC_W), .OFS_W(OFS_W), .CENTER_INC(CENTER), .BANK_MS(BANK)) dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .offset_i(offset_i),
    .ms_tick_i(ms_tick_i), .phase_o(phase_o), .clk_o(clk_o), .clk_en_o(clk_en_o)
  );

  always #10 clk = ~clk;  // 50 MHz

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  bit    done   = 0;
  bit    cmp_on = 0;
  string cur_tag = "R9";

  // Behavioural reference state
  int m_phase = 0;
  int m_msb_prev = 0;
  bit m_prev_trk = 0;
  int m_tick_cnt = 0;
  int m_tick_total = 0;
  int snaps[$];
  int snap_at[$];

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    int step;
    int sz;
    cyc++;
    if (!rst_n) begin
      m_phase = 0; m_msb_prev = 0; m_prev_trk = 0; m_tick_cnt = 0;
      snaps.delete(); snap_at.delete();
    end else begin
      sz   = snaps.size();
      step = CENTER;
      if (mode_i == 2'b01) step += int'($signed(offset_i));
      else if (mode_i == 2'b10 && sz >= 2) step += snaps[sz-2];
      if (ms_tick_i) m_tick_total++;
      // R4: age of the replayed record at the first holdover cycle
      if (mode_i == 2'b10 && m_prev_trk && sz >= 2) begin
        check("R4", "held age lower bound", int'((m_tick_total - snap_at[sz-2]) >= BANK), 1);
        check("R4", "held age upper bound", int'((m_tick_total - snap_at[sz-2]) < 2*BANK), 1);
      end
      m_msb_prev = (m_phase >> (ACC_W-1)) & 1;
      m_phase = (m_phase + step) & MASK;
      if (mode_i == 2'b01) begin
        if (!m_prev_trk) begin
          snaps.delete(); snap_at.delete(); m_tick_cnt = 0;
        end
        if (ms_tick_i) begin
          m_tick_cnt++;
          if (m_tick_cnt % BANK == 0) begin
            snaps.push_back(int'($signed(offset_i)));
            snap_at.push_back(m_tick_total);
          end
        end
        m_prev_trk = 1;
      end else begin
        m_prev_trk = 0;
      end
    end
    if (cyc > 200000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 200000);
      finish_up();
    end
  end

  // Compare away from the active edge, every cycle
  always @(negedge clk) begin
    int msb;
    if (cmp_on) begin
      msb = (m_phase >> (ACC_W-1)) & 1;
      check(cur_tag, "phase", int'(phase_o), m_phase);
      check("R8", "clk_o", int'(clk_o), msb);
      check("R8", "clk_en_o", int'(clk_en_o), int'(msb == 1 && m_msb_prev == 0));
    end
  end

  int gcnt = 0;

  task automatic seg(input string tag, input int n, input logic [1:0] m);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cur_tag   = tag;
      mode_i    = m;
      offset_i  = OFS_W'(((gcnt * 37) % 201) - 100);
      ms_tick_i = (gcnt % TPER == 0);
      gcnt++;
    end
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", "phase in reset", int'(phase_o), 0);
    check("R9", "clk_o in reset", int'(clk_o), 0);
    check("R9", "clk_en_o in reset", int'(clk_en_o), 0);
    rst_n  = 1'b1;
    cmp_on = 1;
    seg("R2", 20, 2'b00);  // free-run, correction moving
    seg("R2", 6,  2'b11);  // unused code behaves as free-run
    seg("R1", 8,  2'b01);  // tracking, no full bank yet
    seg("R5", 10, 2'b10);  // holdover with empty history
    seg("R1", 16, 2'b01);  // fresh entry, one record only
    seg("R5", 6,  2'b10);  // still fewer than two records
    seg("R1", 60, 2'b01);  // long tracking run fills history
    seg("R3", 30, 2'b10);  // replay aged record; ticks continue (R6 frozen)
    seg("R7", 1,  2'b00);
    seg("R7", 1,  2'b01);
    seg("R7", 1,  2'b10);
    seg("R7", 1,  2'b01);
    seg("R2", 10, 2'b00);
    seg("R6", 20, 2'b01);  // re-entry discards older records
    seg("R6", 10, 2'b10);  // only one new record: centre step
    seg("R1", 40, 2'b01);
    seg("R3", 12, 2'b10);
    @(negedge clk);
    cmp_on = 0;
    finish_up();
  end

endmodule